// File: doc/BRIEF.md
# Wake-Up Event Interrupt Controller

This block collects the wake-up events of a low-power receiver and merges them into one active-low interrupt request for a host microcontroller. Four sources feed it: the wake-up timer running out, a low supply voltage, the receive FIFO reaching its fill level, and a request arriving over the serial control port. Each source has its own cause bit. The bit is set when its event occurs and stays set until the host completes a status read, so the host can find out which source woke it.

The block also drives the clock that the host runs on. While the oscillator enable is high, the host clock toggles on every cycle of the block clock. When the enable is cleared, the clock does not stop at once. It delivers a fixed tail of further pulses, 128 by default, so that the host can put itself to sleep in an orderly way. If the enable returns during the tail, the countdown is dropped and the clock keeps running.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset all cause bits read 0, `irq_n_o` is high and `host_clk_o` is low.
- R2: A rising edge on an enabled event input sets its cause bit at the next clock edge. The bit positions are: bit 0 timer expiry, bit 1 low supply, bit 2 FIFO fill, bit 3 serial request.
- R3: A cause bit stays set after its event input returns low, until a status read strobe is given.
- R4: A status read strobe clears every cause bit at the next clock edge. When an enabled event edge falls in the same cycle as the strobe, that source's bit is set rather than cleared.
- R5: A source whose enable is low never sets its cause bit, even when its event input pulses.
- R6: `irq_n_o` is low exactly when at least one cause bit is set and its source is enabled. Clearing the enable of a pending source releases the request but keeps the cause bit visible.
- R7: An event input held high sets its bit only once. After a read clears the bit, the bit does not set again until the input falls and rises again.
- R8: While `osc_en_i` is high, `host_clk_o` changes level on every clock edge.
- R9: After `osc_en_i` is seen low, `host_clk_o` produces exactly `TAIL_PULSES` (128) rising edges, then stays low.
- R10: Raising `osc_en_i` again during the tail cancels the countdown, and the host clock keeps toggling without a break.
- R11: Once the tail has ended and `osc_en_i` stays low, `host_clk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, taken from the reference oscillator |
| rst_n | input | 1 | Power-on reset, active low |
| evt_i | input | N_SRC | Event inputs, one per wake-up source |
| src_en_i | input | N_SRC | Per-source enables |
| stat_rd_i | input | 1 | Strobe marking a completed status read |
| osc_en_i | input | 1 | Oscillator enable; a high-to-low change starts the clock tail |
| irq_n_o | output | 1 | Interrupt request to the host, active low |
| cause_o | output | N_SRC | Latched cause bits |
| host_clk_o | output | 1 | Clock for the host |

## Verification
The bench sweeps every combination of enable mask and event pattern. A design that let a disabled source through, or that drove the request from disabled bits, would show a wrong cause word or a wrong request level. It puts an event edge in the same cycle as a read, where a design giving the clear priority would lose a wake-up. It also holds an input high across a read, where a level-sensitive latch would set the bit again. For the clock tail it counts rising edges after the enable drops, from both clock phases, and then re-raises the enable partway through. An off-by-one counter would produce 127 or 129 pulses, and a missed cancel would stop the clock while the enable is high.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

   localparam int NUM_SRC = 4;

   // Bit position of each wake-up source in the cause word
   typedef enum logic [1:0] {
      SRC_TIMER  = 2'd0,
      SRC_LOWBAT = 2'd1,
      SRC_FIFO   = 2'd2,
      SRC_SERIAL = 2'd3
   } wake_src_e;

endpackage

// File: rtl/wake_cause_bit.sv
module wake_cause_bit #(
   parameter bit EDGE_CAPTURE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic en_i,
   input  logic clr_i,
   output logic pend_o
);

   logic hit;

   generate
      if (EDGE_CAPTURE) begin : g_edge
         logic evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= 1'b0;
            else        evt_q <= evt_i;
         end
         assign hit = evt_i & ~evt_q;
      end else begin : g_level
         assign hit = evt_i;
      end
   endgenerate

   logic set_q;
   assign set_q = hit & en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_o <= 1'b0;
      else if (set_q) pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
   end

   // R5: a disabled source cannot raise its bit
   assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !pend_o) |=> !pend_o);

   // R2: an accepted event is visible on the next edge
   assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && hit) |=> pend_o);

   // R4: a read with the source disabled always clears
   assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !en_i) |=> !pend_o);

   // R3: a pending bit survives until a read
   assert_bit_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_i) |=> pend_o);

endmodule

// File: rtl/wake_clk_tail.sv
module wake_clk_tail #(
   parameter int TAIL_PULSES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en_i,
   output logic host_clk_o
);

   localparam int CW = $clog2(TAIL_PULSES + 1);
   localparam logic [CW-1:0] TAIL_LOAD = CW'(TAIL_PULSES);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_clk_o <= 1'b0;
         left_q     <= '0;
      end else if (osc_en_i) begin
         host_clk_o <= ~host_clk_o;
         left_q     <= TAIL_LOAD;
      end else if (left_q != '0) begin
         host_clk_o <= ~host_clk_o;
         if (!host_clk_o) left_q <= left_q - 1'b1;
      end else begin
         host_clk_o <= 1'b0;
      end
   end

   // R8: continuous toggling while enabled
   assert_clk_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_i |=> (host_clk_o != $past(host_clk_o)));

   // R11: an exhausted tail with the enable low keeps the clock parked
   assert_clk_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en_i && left_q == '0 && !host_clk_o) |=> !host_clk_o);

   // R9: the countdown never exceeds its load value
   assert_tail_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= TAIL_LOAD);

endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl #(
   parameter int N_SRC        = wake_irq_pkg::NUM_SRC,
   parameter int TAIL_PULSES  = 128,
   parameter bit EDGE_CAPTURE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] src_en_i,
   input  logic             stat_rd_i,
   input  logic             osc_en_i,
   output logic             irq_n_o,
   output logic [N_SRC-1:0] cause_o,
   output logic             host_clk_o
);

   initial begin
      assert (N_SRC >= 1 && N_SRC <= 32)
         else $error("N_SRC must lie in 1..32");
      assert (TAIL_PULSES >= 1)
         else $error("TAIL_PULSES must be at least 1");
   end

   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         wake_cause_bit #(
            .EDGE_CAPTURE(EDGE_CAPTURE)
         ) i_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[s]),
            .en_i   (src_en_i[s]),
            .clr_i  (stat_rd_i),
            .pend_o (cause_o[s])
         );
      end
   endgenerate

   logic [N_SRC-1:0] live;
   assign live    = cause_o & src_en_i;
   assign irq_n_o = ~(|live);

   wake_clk_tail #(
      .TAIL_PULSES(TAIL_PULSES)
   ) i_tail (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_en_i   (osc_en_i),
      .host_clk_o (host_clk_o)
   );

   // R6: an active request always has a latched cause behind it
   assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_o |-> (cause_o != '0));

   // R6: with every source disabled no request is raised
   assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en_i == '0) |-> irq_n_o);

endmodule

// File: tb/test_wake_irq_ctrl.sv
`timescale 1ns/1ps
module test_wake_irq_ctrl;

   localparam int N = 4;
   localparam int TAIL = 128;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic [N-1:0] en = '0;
   logic         rd = 1'b0;
   logic         osc = 1'b0;
   logic         irq_n;
   logic [N-1:0] cause;
   logic         hclk;

   int errs = 0;
   int checks = 0;

   always #2 clk = ~clk;

   wake_irq_ctrl #(.N_SRC(N), .TAIL_PULSES(TAIL)) i_wake_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .src_en_i(en),
      .stat_rd_i(rd), .osc_en_i(osc), .irq_n_o(irq_n),
      .cause_o(cause), .host_clk_o(hclk)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_read();
      rd = 1'b1; tick(); rd = 1'b0;
   endtask

   // Counts rising edges of the host clock seen over n negedge samples
   task automatic count_rises(input int n, output int rises);
      logic prev;
      rises = 0;
      prev = hclk;
      for (int k = 0; k < n; k++) begin
         tick();
         if (hclk && !prev) rises++;
         prev = hclk;
      end
   endtask

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1 cause", 32'(cause), 0);
      chk("R1 irq_n", 32'(irq_n), 1);
      chk("R1 hclk", 32'(hclk), 0);
      rst_n = 1'b1;
      tick();

      // R2 R5 R6: every enable mask against every event pattern
      for (int m = 0; m < 16; m++) begin
         for (int p = 0; p < 16; p++) begin
            en = 4'(m);
            evt = 4'(p); tick();
            evt = '0;    tick();
            chk("R2/R5 cause", 32'(cause), 32'(m & p));
            chk("R6 irq_n", 32'(irq_n), ((m & p) != 0) ? 0 : 1);
            do_read();
            chk("R4 cleared", 32'(cause), 0);
            chk("R6 released", 32'(irq_n), 1);
         end
      end

      // R3: the bit stays set over many idle cycles
      en = 4'hF;
      evt = 4'b0100; tick(); evt = '0;
      repeat (20) tick();
      chk("R3 sticky", 32'(cause), 32'h4);
      do_read();

      // R4: an edge coinciding with the read wins for its own source
      evt = 4'b0001; tick(); evt = '0; tick();
      evt = 4'b1000; rd = 1'b1; tick(); evt = '0; rd = 1'b0;
      chk("R4 collide", 32'(cause), 32'h8);
      do_read();

      // R6: disabling a pending source drops the request, keeps the cause
      evt = 4'b0010; tick(); evt = '0; tick();
      en = 4'b1101; tick();
      chk("R6 masked irq", 32'(irq_n), 1);
      chk("R6 cause kept", 32'(cause), 32'h2);
      en = 4'hF; tick();
      chk("R6 re-enabled irq", 32'(irq_n), 0);
      do_read();

      // R7: a held-high input sets only once
      evt = 4'b0001; tick(); tick();
      do_read();
      repeat (5) tick();
      chk("R7 no reset", 32'(cause), 0);
      evt = '0; tick();
      evt = 4'b0001; tick();
      chk("R7 new edge", 32'(cause), 32'h1);
      evt = '0;
      do_read();

      // R5: a source disabled during a pulse and enabled afterwards stays clear
      en = 4'b0111;
      evt = 4'b1000; tick(); evt = '0; tick();
      en = 4'hF; tick();
      chk("R5 late enable", 32'(cause), 0);
      chk("R5 irq idle", 32'(irq_n), 1);

      // R8: the host clock toggles every cycle
      osc = 1'b1; tick();
      begin
         logic prev;
         int bad;
         bad = 0;
         prev = hclk;
         for (int k = 0; k < 40; k++) begin
            tick();
            if (hclk == prev) bad++;
            prev = hclk;
         end
         chk("R8 toggling", 32'(bad), 0);
      end

      // R9 R11: tail from both clock phases
      for (int ph = 0; ph < 2; ph++) begin
         int r;
         osc = 1'b1;
         repeat (10 + ph) tick();
         osc = 1'b0;
         count_rises(2 * TAIL + 20, r);
         chk("R9 tail count", 32'(r), 32'(TAIL));
         count_rises(30, r);
         chk("R11 stays low rises", 32'(r), 0);
         chk("R11 stays low level", 32'(hclk), 0);
      end

      // R10: re-enable during the tail cancels the stop
      begin
         int r;
         osc = 1'b1; repeat (4) tick();
         osc = 1'b0; repeat (50) tick();
         osc = 1'b1;
         count_rises(2 * TAIL + 40, r);
         chk("R10 keeps running", 32'(r), 32'(TAIL + 20));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule